// File: doc/BRIEF.md
# Paged Indirect Register Window Bridge

This bridge gives a narrow host configuration port access to a wide internal register bus through a small address aperture. The host first writes a page number into a page-select register. It then reads or writes inside a fixed 512-byte window. The bridge forwards each window access to the internal bus. The internal address joins the stored page, as the upper bits, with the low nine bits of the host offset, as the lower bits. The page is persistent, so every window access lands on the page most recently written.

The bridge forwards internal bus accesses combinationally. The host port stays stalled until the internal bus signals ready, and internal read data comes back to the host unchanged. Host offsets that hit neither the page-select register nor the window are handed to a separate local register port. The internal bus never sees them.

Top module: `pwin_bridge`

## Requirements
- R1: After reset the stored page is zero. A page read returns 0, and a window access issues internal address bits 31:9 equal to zero.
- R2: A host write to offset 0x41C stores host write data bits 22:0 as the page and ignores bits 31:23. It completes in the cycle it is presented, and neither the internal bus nor the local port is driven.
- R3: A host read of offset 0x41C returns the stored page in bits 22:0 and zero in bits 31:23, and completes in the cycle it is presented.
- R4: A host access at any offset from 0x800 to 0x9FF drives the internal bus with address {page, host offset bits 8:0}. This holds for every byte offset in the window.
- R5: A window write drives the internal write strobe and passes the host write data unchanged to the internal bus.
- R6: A window access holds host ready low until the internal bus asserts ready. It then completes in that same cycle, and read data equals internal read data.
- R7: The page keeps its value across any number of window and local accesses. Only a write to offset 0x41C changes it.
- R8: Host accesses to any other offset go to the local port with the same offset, direction and write data. Local ready and read data are returned to the host, and the internal bus stays idle.
- R9: Only the exact offset 0x41C selects the page register. Neighbours such as 0x418, 0x41D and 0x420 go to the local port, as do the offsets just outside the window (0x7FF, 0xA00), and leave the page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_valid | input | 1 | Host access request, held until h_ready |
| h_write | input | 1 | Host access is a write |
| h_addr | input | 12 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_ready | output | 1 | Host access completes this cycle |
| h_rdata | output | 32 | Host read data, valid with h_ready |
| m_valid | output | 1 | Internal bus request |
| m_write | output | 1 | Internal bus write strobe |
| m_addr | output | 32 | Internal bus address {page, offset} |
| m_wdata | output | 32 | Internal bus write data |
| m_ready | input | 1 | Internal bus completion |
| m_rdata | input | 32 | Internal bus read data |
| l_valid | output | 1 | Local register port request |
| l_write | output | 1 | Local port write strobe |
| l_addr | output | 12 | Local port offset |
| l_wdata | output | 32 | Local port write data |
| l_ready | input | 1 | Local port completion |
| l_rdata | input | 32 | Local port read data |

## Verification
A corrupted or stale page shows up at once on the next window access as wrong internal address bits 31:9. It also shows up as a wrong value on the next page read, so the sweep reads back through many pages and every window offset. A decode error sends a request to the wrong port in the very cycle it is presented. This is caught by watching which bus moves and by counting cycles of internal traffic around page and local accesses. A broken stall path shows up as a wait count that differs from the latency the bus model programmed.

// File: rtl/pwin_pkg.sv
package pwin_pkg;

    localparam int HOST_AW_DEF  = 12;
    localparam int DATA_W_DEF   = 32;
    localparam int INT_AW_DEF   = 32;
    localparam int OFF_W_DEF    = 9;
    localparam int PAGE_OFF_DEF = 'h41C;
    localparam int WIN_BASE_DEF = 'h800;

    // Target of a host access
    typedef enum logic [1:0] {
        TGT_PAGE  = 2'd0,
        TGT_WIN   = 2'd1,
        TGT_LOCAL = 2'd2
    } tgt_e;

endpackage

// File: rtl/pwin_decode.sv
module pwin_decode
    import pwin_pkg::*;
#(
    parameter int HOST_AW  = HOST_AW_DEF,
    parameter int OFF_W    = OFF_W_DEF,
    parameter int PAGE_OFF = PAGE_OFF_DEF,
    parameter int WIN_BASE = WIN_BASE_DEF
) (
    input  logic [HOST_AW-1:0] addr,
    output tgt_e               tgt
);
    localparam int                 TAG_W   = HOST_AW - OFF_W;
    localparam logic [TAG_W-1:0]   WIN_TAG = TAG_W'(WIN_BASE >> OFF_W);
    localparam logic [HOST_AW-1:0] PG_ADDR = HOST_AW'(PAGE_OFF);

    always_comb begin
        if (addr == PG_ADDR) begin
            tgt = TGT_PAGE;
        end else if (addr[HOST_AW-1:OFF_W] == WIN_TAG) begin
            tgt = TGT_WIN;
        end else begin
            tgt = TGT_LOCAL;
        end
    end
endmodule

// File: rtl/pwin_page_reg.sv
module pwin_page_reg #(
    parameter int PAGE_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_page,
    output logic [PAGE_W-1:0] page
);
    always_ff @(posedge clk) begin
        if (rst) begin
            page <= '0;
        end else if (wr_en) begin
            page <= wr_page;
        end
    end
endmodule

// File: rtl/pwin_fwd.sv
module pwin_fwd #(
    parameter int OFF_W  = 9,
    parameter int PAGE_W = 23,
    parameter int DATA_W = 32
) (
    input  logic                    sel,
    input  logic                    wr,
    input  logic [OFF_W-1:0]        win_off,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [PAGE_W-1:0]       page,
    output logic                    m_valid,
    output logic                    m_write,
    output logic [PAGE_W+OFF_W-1:0] m_addr,
    output logic [DATA_W-1:0]       m_wdata,
    input  logic                    m_ready,
    input  logic [DATA_W-1:0]       m_rdata,
    output logic                    done,
    output logic [DATA_W-1:0]       rdata
);
    always_comb begin
        m_valid = sel;
        m_write = sel & wr;
        m_addr  = {page, win_off};
        m_wdata = sel ? wdata : '0;
        done    = sel & m_ready;
        rdata   = m_rdata;
    end
endmodule

// File: rtl/pwin_bridge.sv
module pwin_bridge
    import pwin_pkg::*;
#(
    parameter int HOST_AW  = HOST_AW_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int INT_AW   = INT_AW_DEF,
    parameter int OFF_W    = OFF_W_DEF,
    parameter int PAGE_OFF = PAGE_OFF_DEF,
    parameter int WIN_BASE = WIN_BASE_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               h_valid,
    input  logic               h_write,
    input  logic [HOST_AW-1:0] h_addr,
    input  logic [DATA_W-1:0]  h_wdata,
    output logic               h_ready,
    output logic [DATA_W-1:0]  h_rdata,
    output logic               m_valid,
    output logic               m_write,
    output logic [INT_AW-1:0]  m_addr,
    output logic [DATA_W-1:0]  m_wdata,
    input  logic               m_ready,
    input  logic [DATA_W-1:0]  m_rdata,
    output logic               l_valid,
    output logic               l_write,
    output logic [HOST_AW-1:0] l_addr,
    output logic [DATA_W-1:0]  l_wdata,
    input  logic               l_ready,
    input  logic [DATA_W-1:0]  l_rdata
);
    localparam int PAGE_W = INT_AW - OFF_W;

    tgt_e               tgt;
    logic               sel_page;
    logic               sel_win;
    logic               sel_loc;
    logic [PAGE_W-1:0]  page;
    logic               win_done;
    logic [DATA_W-1:0]  win_rdata;

    pwin_decode #(
        .HOST_AW (HOST_AW),
        .OFF_W   (OFF_W),
        .PAGE_OFF(PAGE_OFF),
        .WIN_BASE(WIN_BASE)
    ) u_decode (
        .addr(h_addr),
        .tgt (tgt)
    );

    assign sel_page = h_valid && (tgt == TGT_PAGE);
    assign sel_win  = h_valid && (tgt == TGT_WIN);
    assign sel_loc  = h_valid && (tgt == TGT_LOCAL);

    pwin_page_reg #(
        .PAGE_W(PAGE_W)
    ) u_page (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (sel_page && h_write),
        .wr_page(h_wdata[PAGE_W-1:0]),
        .page   (page)
    );

    pwin_fwd #(
        .OFF_W (OFF_W),
        .PAGE_W(PAGE_W),
        .DATA_W(DATA_W)
    ) u_fwd (
        .sel    (sel_win),
        .wr     (h_write),
        .win_off(h_addr[OFF_W-1:0]),
        .wdata  (h_wdata),
        .page   (page),
        .m_valid(m_valid),
        .m_write(m_write),
        .m_addr (m_addr),
        .m_wdata(m_wdata),
        .m_ready(m_ready),
        .m_rdata(m_rdata),
        .done   (win_done),
        .rdata  (win_rdata)
    );

    // Local register port: direct pass of everything outside page and window
    always_comb begin
        l_valid = sel_loc;
        l_write = sel_loc & h_write;
        l_addr  = h_addr;
        l_wdata = sel_loc ? h_wdata : '0;
    end

    // Host response mux
    always_comb begin
        h_ready = 1'b0;
        h_rdata = '0;
        if (h_valid) begin
            case (tgt)
                TGT_PAGE: begin
                    h_ready = 1'b1;
                    h_rdata = DATA_W'(page);
                end
                TGT_WIN: begin
                    h_ready = win_done;
                    h_rdata = win_rdata;
                end
                default: begin
                    h_ready = l_ready;
                    h_rdata = l_rdata;
                end
            endcase
        end
    end
endmodule

// File: rtl/pwin_bridge_chk.sv
module pwin_bridge_chk #(
    parameter int HOST_AW  = 12,
    parameter int DATA_W   = 32,
    parameter int INT_AW   = 32,
    parameter int OFF_W    = 9,
    parameter int PAGE_OFF = 'h41C
) (
    input logic               clk,
    input logic               rst,
    input logic               h_valid,
    input logic               h_write,
    input logic [HOST_AW-1:0] h_addr,
    input logic [DATA_W-1:0]  h_wdata,
    input logic               h_ready,
    input logic [DATA_W-1:0]  h_rdata,
    input logic               m_valid,
    input logic [INT_AW-1:0]  m_addr,
    input logic               m_ready,
    input logic [DATA_W-1:0]  m_rdata,
    input logic               l_valid
);
    localparam int PAGE_W = INT_AW - OFF_W;
    localparam logic [HOST_AW-1:0] PG_ADDR = HOST_AW'(PAGE_OFF);

    logic [PAGE_W-1:0]        shadow;
    logic [PAGE_W-1:0]        wd_page;
    logic [DATA_W-PAGE_W-1:0] wd_hi_unused;

    assign {wd_hi_unused, wd_page} = h_wdata;

    // Independent record of the page, built from completed host writes
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (h_valid && h_ready && h_write && h_addr == PG_ADDR) begin
            shadow <= wd_page;
        end
    end

    AST_PAGE_READ: assert property (@(posedge clk) disable iff (rst) (h_valid && !h_write && h_addr == PG_ADDR) |-> (h_ready && h_rdata == DATA_W'(shadow))); // R3
    AST_PAGE_NOFWD: assert property (@(posedge clk) disable iff (rst) (h_valid && h_addr == PG_ADDR) |-> (!m_valid && !l_valid)); // R2
    AST_WIN_PAGE: assert property (@(posedge clk) disable iff (rst) m_valid |-> (m_addr[INT_AW-1:OFF_W] == shadow)); // R7
    AST_WIN_OFFSET: assert property (@(posedge clk) disable iff (rst) m_valid |-> (m_addr[OFF_W-1:0] == h_addr[OFF_W-1:0] && h_valid)); // R4
    AST_STALL: assert property (@(posedge clk) disable iff (rst) (m_valid && !m_ready) |-> !h_ready); // R6
    AST_RDATA: assert property (@(posedge clk) disable iff (rst) (m_valid && m_ready && !h_write) |-> (h_ready && h_rdata == m_rdata)); // R6
    AST_ISOLATE: assert property (@(posedge clk) disable iff (rst) m_valid |-> !l_valid); // R8
endmodule

bind pwin_bridge pwin_bridge_chk #(
    .HOST_AW (HOST_AW),
    .DATA_W  (DATA_W),
    .INT_AW  (INT_AW),
    .OFF_W   (OFF_W),
    .PAGE_OFF(PAGE_OFF)
) i_chk (
    .clk    (clk),
    .rst    (rst),
    .h_valid(h_valid),
    .h_write(h_write),
    .h_addr (h_addr),
    .h_wdata(h_wdata),
    .h_ready(h_ready),
    .h_rdata(h_rdata),
    .m_valid(m_valid),
    .m_addr (m_addr),
    .m_ready(m_ready),
    .m_rdata(m_rdata),
    .l_valid(l_valid)
);

// File: tb/test_pwin_bridge.sv
`timescale 1ns/1ps
module test_pwin_bridge;
    localparam logic [31:0] MIX = 32'hC3A5_0F1E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_valid = 1'b0;
    logic        h_write = 1'b0;
    logic [11:0] h_addr  = '0;
    logic [31:0] h_wdata = '0;
    logic        h_ready;
    logic [31:0] h_rdata;
    logic        m_valid, m_write, m_ready;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic        l_valid, l_write, l_ready;
    logic [11:0] l_addr;
    logic [31:0] l_wdata, l_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int fwd_cyc = 0;
    int loc_cyc = 0;
    logic [1:0]  lat = 2'd0;
    logic [1:0]  cnt;
    logic [31:0] wr_addr, wr_data;
    logic [11:0] lw_addr;
    logic [31:0] lw_data;

    always #5 clk = ~clk;

    pwin_bridge i_pwin_bridge (
        .clk(clk), .rst(rst),
        .h_valid(h_valid), .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_ready(h_ready), .h_rdata(h_rdata),
        .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_ready(m_ready), .m_rdata(m_rdata),
        .l_valid(l_valid), .l_write(l_write), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_ready(l_ready), .l_rdata(l_rdata)
    );

    // Internal bus model with programmable wait states
    always @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (m_valid && !m_ready) cnt <= cnt + 2'd1;
        else cnt <= '0;
        if (m_valid) fwd_cyc <= fwd_cyc + 1;
        if (m_valid && m_ready && m_write) begin
            wr_addr <= m_addr;
            wr_data <= m_wdata;
        end
        if (l_valid) loc_cyc <= loc_cyc + 1;
        if (l_valid && l_write) begin
            lw_addr <= l_addr;
            lw_data <= l_wdata;
        end
    end
    assign m_ready = m_valid && (cnt == lat);
    assign m_rdata = m_addr ^ MIX;
    assign l_ready = l_valid;
    assign l_rdata = {20'hB0C00, l_addr};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d,
                          input logic [1:0] lt, output logic [31:0] rd,
                          output logic [31:0] ma, output int waits);
        @(negedge clk);
        lat = lt;
        h_valid = 1'b1; h_write = w; h_addr = a; h_wdata = d;
        waits = 0;
        #1;
        while (!h_ready) begin
            @(negedge clk);
            waits++;
            #1;
        end
        rd = h_rdata;
        ma = m_addr;
        @(posedge clk);
        @(negedge clk);
        h_valid = 1'b0; h_write = 1'b0; h_addr = '0; h_wdata = '0;
    endtask

    task automatic read_page(input string tag, input logic [22:0] exp);
        logic [31:0] rd, ma;
        int w, f0;
        f0 = fwd_cyc;
        access(1'b0, 12'h41C, 32'h0, 2'd0, rd, ma, w);
        chk(tag, rd, {9'h0, exp});
        chk(tag, 32'(w), 32'd0);
        chk(tag, 32'(fwd_cyc - f0), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] rd, ma;
        int w, f0, l0;
        logic [22:0] pages [4];
        logic [11:0] locs [8];
        pages[0] = 23'h000001; pages[1] = 23'h2AAAAA;
        pages[2] = 23'h555555; pages[3] = 23'h7FFFFF;
        locs[0] = 12'h000; locs[1] = 12'h418; locs[2] = 12'h41D; locs[3] = 12'h420;
        locs[4] = 12'h7FF; locs[5] = 12'hA00; locs[6] = 12'hFFC; locs[7] = 12'h41F;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        read_page("R1 page after reset", 23'h0);
        access(1'b0, 12'h8A4, 32'h0, 2'd1, rd, ma, w);
        chk("R1 window addr at page 0", ma, 32'h0000_00A4);

        // R2/R3: upper write bits dropped, page not forwarded
        f0 = fwd_cyc; l0 = loc_cyc;
        access(1'b1, 12'h41C, 32'hFFFF_FFFF, 2'd0, rd, ma, w);
        chk("R2 page write no wait", 32'(w), 32'd0);
        chk("R2 page write not forwarded", 32'(fwd_cyc - f0), 32'd0);
        chk("R2 page write not local", 32'(loc_cyc - l0), 32'd0);
        read_page("R3 page readback masked", 23'h7FFFFF);

        // R4/R6/R7: sweep every word offset of the window on several pages
        foreach (pages[p]) begin
            access(1'b1, 12'h41C, {9'h1A5, pages[p]}, 2'd0, rd, ma, w);
            for (int o = 0; o < 512; o += 4) begin
                logic [8:0] off;
                off = 9'(o) | 9'(p);
                access(1'b0, 12'h800 | 12'(off), 32'h0, off[3:2], rd, ma, w);
                chk("R4 window addr", ma, {pages[p], off});
                chk("R6 read data", rd, {pages[p], off} ^ MIX);
                chk("R6 stall cycles", 32'(w), 32'(off[3:2]));
            end
            read_page("R7 page persists after sweep", pages[p]);
        end

        // R4: window byte boundaries
        access(1'b0, 12'h9FF, 32'h0, 2'd3, rd, ma, w);
        chk("R4 top byte of window", ma, {23'h7FFFFF, 9'h1FF});
        access(1'b0, 12'h800, 32'h0, 2'd0, rd, ma, w);
        chk("R4 bottom of window", ma, {23'h7FFFFF, 9'h000});

        // R5: window writes
        access(1'b1, 12'h41C, 32'h0012_3456, 2'd0, rd, ma, w);
        access(1'b1, 12'h9F0, 32'hDEAD_BEEF, 2'd2, rd, ma, w);
        chk("R5 write addr", wr_addr, {23'h123456, 9'h1F0});
        chk("R5 write data", wr_data, 32'hDEAD_BEEF);
        chk("R6 write stall", 32'(w), 32'd2);
        access(1'b1, 12'h803, 32'h0BAD_F00D, 2'd0, rd, ma, w);
        chk("R5 write addr low", wr_addr, {23'h123456, 9'h003});
        chk("R5 write data low", wr_data, 32'h0BAD_F00D);

        // R8/R9: local port traffic, page untouched
        foreach (locs[i]) begin
            f0 = fwd_cyc; l0 = loc_cyc;
            access(1'b0, locs[i], 32'h0, 2'd0, rd, ma, w);
            chk("R8 local read data", rd, {20'hB0C00, locs[i]});
            chk("R8 internal idle on local read", 32'(fwd_cyc - f0), 32'd0);
            chk("R8 local used once", 32'(loc_cyc - l0), 32'd1);
            access(1'b1, locs[i], {20'h5A5A5, locs[i]}, 2'd0, rd, ma, w);
            chk("R8 local write addr", {20'h0, lw_addr}, {20'h0, locs[i]});
            chk("R8 local write data", lw_data, {20'h5A5A5, locs[i]});
            read_page("R9 page unchanged by neighbour", 23'h123456);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule